// File: doc/BRIEF.md
# Two-length flat prefix code assigner

The block maps a symbol index to a canonical prefix codeword. The only other input is the total number of distinct symbols, N. It uses no frequency table and builds no tree. With k = floor(log2 N), every codeword is either k or k+1 bits long. The short codewords go to the lowest indices, which a caller reserves for its most frequent symbols. The number of long codewords is twice the excess of N over 2^k. The boundary index between the two groups is found arithmetically from N alone.

Requests enter as a count and an index qualified by a valid strobe, and one request can be accepted every cycle. Stage one finds k, the number of short codewords S = 2^(k+1) - N, and the class of the index: short, long or out of range. Stage two forms the codeword and its length. A result therefore appears two clock edges after its request. An index at or above N, or a count outside the legal range, gives a flagged result with zero length.

Top module: `pfx_flat_coder`

## Requirements
- R1: While reset is held, and after it is released until the first result, `out_valid`, `codeword`, `code_len` and `out_of_range` are all 0.
- R2: A request taken on a rising edge with `req_valid` high produces `out_valid` high exactly on the second rising edge after it, for one cycle. Requests on consecutive cycles produce results on consecutive cycles.
- R3: For a legal count N, with k = floor(log2 N), exactly 2*(N - 2^k) indices get length k+1. The remaining N - 2*(N - 2^k) indices get length k. For N = 300 this gives 88 nine-bit and 212 eight-bit codewords.
- R4: An index i below S = N - 2*(N - 2^k) gets `codeword` = i and `code_len` = k.
- R5: An index i with S <= i < N gets `codeword` = i + S and `code_len` = k+1, so the long codewords fill the range 2S to 2^(k+1)-1. For N = 300 the range is 424 to 511.
- R6: When N is an exact power of two, every index gets `codeword` = i and `code_len` = k, including N = 2^32 where the length is 32.
- R7: An index i >= N gives `out_of_range` = 1 with `codeword` = 0 and `code_len` = 0.
- R8: A count below 2 or above 2^32 gives `out_of_range` = 1, `codeword` = 0 and `code_len` = 0 for any index.
- R9: In a cycle where `out_valid` is 0, `codeword`, `code_len` and `out_of_range` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Qualifies `sym_count` and `sym_index` this cycle |
| sym_count | input | 33 | Number of distinct symbols N |
| sym_index | input | 32 | Symbol index to encode |
| out_valid | output | 1 | Result present this cycle |
| codeword | output | 32 | Codeword, right-aligned in the low `code_len` bits |
| code_len | output | 6 | Codeword length in bits, 0 when flagged |
| out_of_range | output | 1 | Index or count illegal |

## Verification
Two things happen in the same cycle. Stage one classifies a new request while stage two emits the codeword of the previous one, and the two requests may carry different counts. The bench streams requests back to back and changes the count on every request. It alternates short, long and out-of-range indices, so each stage must keep its own copy of k and S. Every cycle, including idle gaps, is compared against a behavioural model that delays its expectations by two cycles. A complete sweep of several counts also tallies the observed long lengths against the required 2*(N - 2^k).

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Class of a request, decided in stage one.
    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_LONG  = 2'd1,
        CLS_RANGE = 2'd2
    } sym_cls_e;

endpackage

// File: rtl/pfx_msb_find.sv
// Position of the highest set bit (floor log2); 0 for an all-zero input.
module pfx_msb_find #(
    parameter int W = 33
) (
    input  logic [W-1:0]         val,
    output logic [$clog2(W)-1:0] pos
);
    logic [W-1:0] top_hit;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            if (g == W - 1) begin : g_top
                assign top_hit[g] = val[g];
            end else begin : g_low
                assign top_hit[g] = val[g] & ~(|val[W-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (top_hit[i]) pos = pos | ($clog2(W))'(i);
        end
    end
endmodule

// File: rtl/pfx_split.sv
// Stage-one logic: k, short-code count S and class of the index (R3, R7, R8).
module pfx_split
    import pfx_pkg::*;
#(
    parameter int CNT_W = 33,
    parameter int IDX_W = CNT_W - 1,
    parameter int LOG_W = $clog2(CNT_W),
    parameter int SUM_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] index,
    output logic [LOG_W-1:0] k,
    output logic [SUM_W-1:0] short_cnt,
    output sym_cls_e         cls
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << (CNT_W - 1);

    logic [SUM_W-1:0] span;
    logic             bad_count;
    logic             bad_index;

    pfx_msb_find #(.W(CNT_W)) u_msb (
        .val (count),
        .pos (k)
    );

    // S = 2^(k+1) - N, equal to N - 2*(N - 2^k)
    assign span      = SUM_W'(1) << (k + LOG_W'(1));
    assign short_cnt = span - SUM_W'(count);

    assign bad_count = (count < CNT_W'(2)) || (count > MAX_CNT);
    assign bad_index = CNT_W'(index) >= count;

    always_comb begin
        if (bad_count || bad_index) begin
            cls = CLS_RANGE;
        end else if (SUM_W'(index) < short_cnt) begin
            cls = CLS_SHORT;
        end else begin
            cls = CLS_LONG;
        end
    end
endmodule

// File: rtl/pfx_emit.sv
// Stage-two logic: codeword and length from the stage-one record (R4, R5, R7).
module pfx_emit
    import pfx_pkg::*;
#(
    parameter int CODE_W = 32,
    parameter int LOG_W  = 6,
    parameter int LEN_W  = 6,
    parameter int SUM_W  = 34
) (
    input  sym_cls_e          cls,
    input  logic [LOG_W-1:0]  k,
    input  logic [SUM_W-1:0]  short_cnt,
    input  logic [CODE_W-1:0] index,
    output logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len,
    output logic              oor
);
    always_comb begin
        unique case (cls)
            CLS_SHORT: begin
                code = index;
                len  = LEN_W'(k);
                oor  = 1'b0;
            end
            CLS_LONG: begin
                // 2S + (i - S) = i + S
                code = CODE_W'(SUM_W'(index) + short_cnt);
                len  = LEN_W'(k) + LEN_W'(1);
                oor  = 1'b0;
            end
            default: begin
                code = '0;
                len  = '0;
                oor  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pfx_flat_coder.sv
module pfx_flat_coder
    import pfx_pkg::*;
#(
    parameter  int CNT_W  = 33,
    localparam int IDX_W  = CNT_W - 1,
    localparam int CODE_W = IDX_W,
    localparam int LOG_W  = $clog2(CNT_W),
    localparam int LEN_W  = LOG_W,
    localparam int SUM_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  sym_count,
    input  logic [IDX_W-1:0]  sym_index,
    output logic              out_valid,
    output logic [CODE_W-1:0] codeword,
    output logic [LEN_W-1:0]  code_len,
    output logic              out_of_range
);
    // stage-one combinational results
    logic [LOG_W-1:0]  sp_k;
    logic [SUM_W-1:0]  sp_s;
    sym_cls_e          sp_cls;

    // stage-one registers
    logic              s1_vld;
    logic [LOG_W-1:0]  s1_k;
    logic [SUM_W-1:0]  s1_s;
    logic [IDX_W-1:0]  s1_idx;
    sym_cls_e          s1_cls;

    // stage-two combinational results
    logic [CODE_W-1:0] em_code;
    logic [LEN_W-1:0]  em_len;
    logic              em_oor;

    pfx_split #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .LOG_W (LOG_W),
        .SUM_W (SUM_W)
    ) u_split (
        .count     (sym_count),
        .index     (sym_index),
        .k         (sp_k),
        .short_cnt (sp_s),
        .cls       (sp_cls)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_k   <= '0;
            s1_s   <= '0;
            s1_idx <= '0;
            s1_cls <= CLS_RANGE;
        end else begin
            s1_vld <= req_valid;
            if (req_valid) begin
                s1_k   <= sp_k;
                s1_s   <= sp_s;
                s1_idx <= sym_index;
                s1_cls <= sp_cls;
            end
        end
    end

    pfx_emit #(
        .CODE_W (CODE_W),
        .LOG_W  (LOG_W),
        .LEN_W  (LEN_W),
        .SUM_W  (SUM_W)
    ) u_emit (
        .cls       (s1_cls),
        .k         (s1_k),
        .short_cnt (s1_s),
        .index     (s1_idx),
        .code      (em_code),
        .len       (em_len),
        .oor       (em_oor)
    );

    // Output register; idle cycles drive zeros (R1, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            codeword     <= '0;
            code_len     <= '0;
            out_of_range <= 1'b0;
        end else begin
            out_valid    <= s1_vld;
            codeword     <= s1_vld ? em_code : '0;
            code_len     <= s1_vld ? em_len  : '0;
            out_of_range <= s1_vld & em_oor;
        end
    end
endmodule

// File: rtl/pfx_flat_coder_chk.sv
module pfx_flat_coder_chk
    import pfx_pkg::*;
#(
    parameter  int CNT_W  = 33,
    localparam int IDX_W  = CNT_W - 1,
    localparam int CODE_W = IDX_W,
    localparam int LOG_W  = $clog2(CNT_W),
    localparam int LEN_W  = LOG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              out_valid,
    input logic [CODE_W-1:0] codeword,
    input logic [LEN_W-1:0]  code_len,
    input logic              out_of_range,
    input logic              s1_vld,
    input logic [LOG_W-1:0]  s1_k,
    input logic [IDX_W-1:0]  s1_idx,
    input sym_cls_e          s1_cls
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd3)  warm <= warm + 2'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(req_valid, 2)));

    p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_cls == CLS_SHORT) |=>
            (code_len == LEN_W'($past(s1_k)) && codeword == CODE_W'($past(s1_idx))));

    p_long_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_cls == CLS_LONG) |=>
            (code_len == LEN_W'($past(s1_k)) + LEN_W'(1) && !out_of_range));

    p_fits_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_of_range) |-> ((codeword >> code_len) == '0));

    p_range_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_of_range) |-> (code_len == '0 && codeword == '0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (code_len == '0 && codeword == '0 && !out_of_range));
endmodule

bind pfx_flat_coder pfx_flat_coder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .out_valid    (out_valid),
    .codeword     (codeword),
    .code_len     (code_len),
    .out_of_range (out_of_range),
    .s1_vld       (s1_vld),
    .s1_k         (s1_k),
    .s1_idx       (s1_idx),
    .s1_cls       (s1_cls)
);

// File: tb/pfx_flat_coder_bench.sv
`timescale 1ns/1ps
module pfx_flat_coder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [32:0] sym_count = '0;
    logic [31:0] sym_index = '0;
    logic        out_valid;
    logic [31:0] codeword;
    logic [5:0]  code_len;
    logic        out_of_range;

    int nchecks = 0;
    int nerrs   = 0;
    bit done    = 1'b0;
    int tally_long = 0;

    // two-entry expectation pipe, index 1 is due now
    bit     pv [2];
    bit     pf [2];
    int     pl [2];
    longint pc [2];
    int     pk [2];
    string  pt [2];

    always #2.5 clk = ~clk;

    pfx_flat_coder u_pfx_flat_coder (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .sym_count    (sym_count),
        .sym_index    (sym_index),
        .out_valid    (out_valid),
        .codeword     (codeword),
        .code_len     (code_len),
        .out_of_range (out_of_range)
    );

    task automatic ref_code(input longint n, input longint idx,
                            output bit fl, output int ln, output longint cd, output int kk);
        longint nlong, nshort;
        kk = 0;
        while ((longint'(1) << (kk + 1)) <= n) kk++;
        if (n < 2 || n > (longint'(1) << 32) || idx >= n) begin
            fl = 1'b1; ln = 0; cd = 0;
        end else begin
            fl = 1'b0;
            nlong  = 2 * (n - (longint'(1) << kk));
            nshort = n - nlong;
            if (idx < nshort) begin
                cd = idx; ln = kk;
            end else begin
                cd = 2 * nshort + (idx - nshort); ln = kk + 1;
            end
        end
    endtask

    task automatic compare_due();
        nchecks++;
        if (pv[1]) begin
            if (out_valid !== 1'b1 || out_of_range !== pf[1] || int'(code_len) != pl[1]
                || codeword !== pc[1][31:0]) begin
                nerrs++;
                $display("FAIL %s: got v=%0b oor=%0b len=%0d code=%0h, expected v=1 oor=%0b len=%0d code=%0h",
                         pt[1], out_valid, out_of_range, code_len, codeword, pf[1], pl[1], pc[1][31:0]);
            end
            if (!pf[1] && int'(code_len) == pk[1] + 1) tally_long++;
        end else begin
            if (out_valid !== 1'b0 || out_of_range !== 1'b0 || code_len !== '0 || codeword !== '0) begin
                nerrs++;
                $display("FAIL %s: got v=%0b oor=%0b len=%0d code=%0h, expected all zero",
                         pt[1], out_valid, out_of_range, code_len, codeword);
            end
        end
    endtask

    task automatic step(input bit v, input longint n, input longint idx, input string tag);
        bit fl; int ln; longint cd; int kk;
        @(negedge clk);
        compare_due();
        pv[1] = pv[0]; pf[1] = pf[0]; pl[1] = pl[0]; pc[1] = pc[0]; pk[1] = pk[0]; pt[1] = pt[0];
        ref_code(n, idx, fl, ln, cd, kk);
        pv[0] = v; pf[0] = fl; pl[0] = ln; pc[0] = cd; pk[0] = kk;
        pt[0] = v ? tag : "R2/R9 idle";
        req_valid = v;
        sym_count = n[32:0];
        sym_index = idx[31:0];
    endtask

    task automatic check_count(input string tag, input int got, input int exp);
        nchecks++;
        if (got != exp) begin
            nerrs++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            pv[i] = 0; pf[i] = 0; pl[i] = 0; pc[i] = 0; pk[i] = 0; pt[i] = "R1 reset";
        end
        // R1: held in reset
        repeat (3) begin
            @(negedge clk);
            check_count("R1 out_valid", int'(out_valid), 0);
            check_count("R1 code_len", int'(code_len), 0);
            check_count("R1 codeword", int'(codeword != 0), 0);
        end
        rst_n = 1'b1;
        step(0, 0, 0, "R1");
        step(0, 0, 0, "R1");

        // R3/R4/R5 with N = 300, back to back
        step(1, 300, 0,   "R4 N300 i0");
        step(1, 300, 211, "R4 N300 last short");
        step(1, 300, 212, "R5 N300 first long");
        step(1, 300, 299, "R5 N300 last long");
        step(1, 300, 300, "R7 N300 i300");
        // alternating counts every cycle
        step(1, 3, 1, "R5 N3 i1");
        step(1, 5, 2, "R4 N5 i2");
        step(1, 5, 4, "R5 N5 i4");
        step(1, 3, 7, "R7 N3 i7");
        step(1, 2, 1, "R6 N2 i1");
        step(0, 0, 0, "");
        step(1, 64, 63, "R6 N64 i63");
        step(0, 0, 0, "");
        step(0, 0, 0, "");
        // widest counts
        step(1, longint'(1) << 32, 0, "R6 N2^32 i0");
        step(1, longint'(1) << 32, (longint'(1) << 32) - 1, "R6 N2^32 imax");
        step(1, (longint'(1) << 32) - 1, 0, "R4 Nmax-1 i0");
        step(1, (longint'(1) << 32) - 1, 1, "R5 Nmax-1 i1");
        step(1, (longint'(1) << 32) - 1, (longint'(1) << 32) - 2, "R5 Nmax-1 ilast");
        step(1, (longint'(1) << 32) - 1, (longint'(1) << 32) - 1, "R7 Nmax-1 ioverflow");
        // illegal counts
        step(1, 0, 0, "R8 N0");
        step(1, 1, 0, "R8 N1");
        step(1, (longint'(1) << 32) + 1, 5, "R8 N2^32+1");
        step(1, (longint'(1) << 33) - 1, 0, "R8 Nall-ones");
        step(0, 0, 0, "");
        step(0, 0, 0, "");

        // R3: full sweeps, tally long lengths
        for (int n = 3; n <= 40; n++) begin
            int kk;
            kk = 0;
            while ((1 << (kk + 1)) <= n) kk++;
            tally_long = 0;
            for (int i = 0; i < n; i++) step(1, n, i, "R3 sweep");
            step(0, 0, 0, "");
            step(0, 0, 0, "");
            check_count("R3 long count", tally_long, 2 * (n - (1 << kk)));
        end
        tally_long = 0;
        for (int i = 0; i < 300; i++) step(1, 300, i, "R3 N300 sweep");
        step(0, 0, 0, "");
        step(0, 0, 0, "");
        check_count("R3 N300 nine-bit count", tally_long, 88);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchecks++;
            nerrs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end
endmodule